// File: doc/BRIEF.md
# Prioritized Branch Selector with Operand Isolation

This block takes a four-bit vector of prioritized conditions and one shared data word. It returns the result of exactly one of five branch computations. Conditions are ranked by index, and index 0 is the most urgent. The first condition that is set picks its branch. When no condition is set, a default pass-through branch is chosen. The result is built by a serial chain of 2:1 multiplexers. Each stage is steered by its own condition bit. The default branch feeds the deepest stage. The select path therefore crosses up to one stage per condition.

Each branch has a front-end stage that holds its operand. A build parameter chooses between two forms of this stage. In the low-power form, each branch's operand passes through a level-sensitive hold stage. That stage is transparent only while its branch is the chosen one. Branches that are not chosen keep their last operand, so their arithmetic stays quiet. In the plain form, the hold stages become wires. The chosen result is the same in both forms. The held operand of every branch is brought out on a wide observation port.

The block is purely combinational apart from the level-sensitive hold stages. It is meant to sit inside a larger datapath, with conditions and data coming from surrounding registers.

Top module: `prio_branch_sel`

## Requirements
- R1: When condVec[0] is 1, result equals dataIn + ADD_CONST modulo 2^WIDTH, whatever the other condition bits are.
- R2: When condVec[0] is 0 and k is the lowest index with condVec[k] = 1, result is branch k's value: branch 1 is dataIn XOR XOR_MASK, branch 2 is dataIn shifted left by SHIFT_AMT with zero fill (truncated to WIDTH), and branch 3 is the bitwise inverse of dataIn.
- R3: When all condition bits are 0, result equals dataIn (the default branch, index 4).
- R4: Condition bits with a higher index than the first set bit have no effect on result.
- R5: With LOWPOWER=1, the held operand of the chosen branch equals dataIn.
- R6: With LOWPOWER=1, the held operand of a branch that is not chosen keeps the value of dataIn from the last time that branch was chosen, even when dataIn changes.
- R7: With LOWPOWER=0, the held operand of every branch equals dataIn.
- R8: For every condition and data pattern, result is the same for LOWPOWER=1 and LOWPOWER=0.
- R9: heldOperands packs branch k's operand in bits [k*WIDTH +: WIDTH]. k = 0..3 follow condition index, and k = 4 is the default branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| condVec | input | 4 | Prioritized conditions, bit 0 highest priority |
| dataIn | input | WIDTH | Shared operand fed to all branches |
| result | output | WIDTH | Value of the chosen branch |
| heldOperands | output | 5*WIDTH | Operand currently seen by each branch, branch k at [k*WIDTH +: WIDTH] |

## Verification
There are no registers between the ports. Every result and every held operand is therefore due in the same cycle as the stimulus. The bench drives inputs just after a rising edge and samples them at the following falling edge, once the chain has settled. For the isolation checks, the condition vector changes one cycle before the data word. This closes the hold stage of the previously chosen branch before new data arrives. The value that branch must keep is then known exactly from the earlier stimulus.

// File: rtl/psel_pkg.sv
package psel_pkg;

  // Number of prioritized conditions; one extra branch serves as the default.
  localparam int NUM_COND   = 4;
  localparam int NUM_BRANCH = NUM_COND + 1;
  localparam int DEFAULT_IX = NUM_COND;

  // Branch operation codes, indexed by branch position.
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_XOR  = 3'd1,
    OP_SHL  = 3'd2,
    OP_INV  = 3'd3,
    OP_PASS = 3'd4
  } branchOp_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_BRANCH-1:0] latchOpen;  // one-hot: branch allowed to see new operands
    logic [NUM_COND-1:0]   stageSel;   // per-stage steering of the mux chain
  } selStrobes_t;

  function automatic branchOp_e opForBranch(input int idx);
    case (idx)
      0:       return OP_ADD;
      1:       return OP_XOR;
      2:       return OP_SHL;
      3:       return OP_INV;
      default: return OP_PASS;
    endcase
  endfunction

endpackage

// File: rtl/psel_ctrl.sv
module psel_ctrl
  import psel_pkg::*;
(
  input  logic [NUM_COND-1:0] condVec,
  output selStrobes_t         strobes
);

  // higherSet[k] is 1 when any condition above k in priority is set.
  logic [NUM_COND:0] higherSet;

  assign higherSet[0] = 1'b0;

  generate
    for (genvar k = 0; k < NUM_COND; k++) begin : gPrio
      assign higherSet[k+1]        = higherSet[k] | condVec[k];
      assign strobes.latchOpen[k]  = condVec[k] & ~higherSet[k];
      assign strobes.stageSel[k]   = condVec[k];
    end
  endgenerate

  // Default branch opens only when nothing above it is asserted.
  assign strobes.latchOpen[DEFAULT_IX] = ~higherSet[NUM_COND];

endmodule

// File: rtl/psel_isolate.sv
module psel_isolate #(
  parameter int WIDTH    = 16,
  parameter bit LOWPOWER = 1'b1
) (
  input  logic             openEn,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] heldQ
);

  generate
    if (LOWPOWER) begin : gLatch
      // Transparent while this branch is chosen, frozen otherwise.
      always_latch begin
        if (openEn) heldQ <= dIn;
      end
    end else begin : gWire
      logic unusedOpen;
      assign unusedOpen = openEn;
      assign heldQ      = dIn;
    end
  endgenerate

endmodule

// File: rtl/psel_branch_op.sv
module psel_branch_op
  import psel_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter branchOp_e        OP        = OP_PASS,
  parameter logic [WIDTH-1:0] ADD_CONST = '0,
  parameter logic [WIDTH-1:0] XOR_MASK  = '0,
  parameter int               SHIFT_AMT = 1
) (
  input  logic [WIDTH-1:0] opIn,
  output logic [WIDTH-1:0] opOut
);

  generate
    case (OP)
      OP_ADD: begin : gAdd
        assign opOut = opIn + ADD_CONST;
      end
      OP_XOR: begin : gXor
        assign opOut = opIn ^ XOR_MASK;
      end
      OP_SHL: begin : gShl
        assign opOut = opIn << SHIFT_AMT;
      end
      OP_INV: begin : gInv
        assign opOut = ~opIn;
      end
      default: begin : gPass
        assign opOut = opIn;
      end
    endcase
  endgenerate

endmodule

// File: rtl/psel_datapath.sv
module psel_datapath
  import psel_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter bit               LOWPOWER  = 1'b1,
  parameter logic [WIDTH-1:0] ADD_CONST = '0,
  parameter logic [WIDTH-1:0] XOR_MASK  = '0,
  parameter int               SHIFT_AMT = 1
) (
  input  selStrobes_t                         strobes,
  input  logic [WIDTH-1:0]                    dataIn,
  output logic [NUM_BRANCH-1:0][WIDTH-1:0]    heldOps,
  output logic [NUM_BRANCH-1:0][WIDTH-1:0]    branchRes,
  output logic [WIDTH-1:0]                    chainOut
);

  // chainNode[k] is the output of mux stage k; the default branch seeds the tail.
  logic [NUM_BRANCH-1:0][WIDTH-1:0] chainNode;

  generate
    for (genvar b = 0; b < NUM_BRANCH; b++) begin : gBranch
      psel_isolate #(
        .WIDTH   (WIDTH),
        .LOWPOWER(LOWPOWER)
      ) uIso (
        .openEn(strobes.latchOpen[b]),
        .dIn   (dataIn),
        .heldQ (heldOps[b])
      );

      psel_branch_op #(
        .WIDTH    (WIDTH),
        .OP       (opForBranch(b)),
        .ADD_CONST(ADD_CONST),
        .XOR_MASK (XOR_MASK),
        .SHIFT_AMT(SHIFT_AMT)
      ) uOp (
        .opIn (heldOps[b]),
        .opOut(branchRes[b])
      );
    end

    assign chainNode[DEFAULT_IX] = branchRes[DEFAULT_IX];

    for (genvar s = NUM_COND - 1; s >= 0; s--) begin : gChain
      assign chainNode[s] = strobes.stageSel[s] ? branchRes[s] : chainNode[s+1];
    end
  endgenerate

  assign chainOut = chainNode[0];

  // Assertions guarding the isolation stages and the chain tail.
  generate
    if (LOWPOWER) begin : gLpChk
      always_comb begin
        for (int b = 0; b < NUM_BRANCH; b++) begin
          if (strobes.latchOpen[b] && !$isunknown(dataIn)) begin
            a_r5_open_stage_passes: assert (heldOps[b] == dataIn)
              else $error("R5: open stage %0d does not pass dataIn", b);
          end
        end
      end
    end else begin : gWireChk
      always_comb begin
        if (!$isunknown(dataIn)) begin
          for (int b = 0; b < NUM_BRANCH; b++) begin
            a_r7_wire_stage_passes: assert (heldOps[b] == dataIn)
              else $error("R7: wired stage %0d differs from dataIn", b);
          end
        end
      end
    end
  endgenerate

  always_comb begin
    if (strobes.stageSel == '0 && !$isunknown(branchRes[DEFAULT_IX])) begin
      a_r3_tail_reaches_output: assert (chainOut == branchRes[DEFAULT_IX])
        else $error("R3: default branch not routed to output");
    end
  end

endmodule

// File: rtl/prio_branch_sel.sv
module prio_branch_sel
  import psel_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter bit               LOWPOWER  = 1'b1,
  parameter logic [WIDTH-1:0] ADD_CONST = 16'h0035,
  parameter logic [WIDTH-1:0] XOR_MASK  = 16'hA5C3,
  parameter int               SHIFT_AMT = 3
) (
  input  logic [NUM_COND-1:0]         condVec,
  input  logic [WIDTH-1:0]            dataIn,
  output logic [WIDTH-1:0]            result,
  output logic [NUM_BRANCH*WIDTH-1:0] heldOperands
);

  selStrobes_t                      strobes;
  logic [NUM_BRANCH-1:0][WIDTH-1:0] heldOps;
  logic [NUM_BRANCH-1:0][WIDTH-1:0] branchRes;

  psel_ctrl uCtrl (
    .condVec(condVec),
    .strobes(strobes)
  );

  psel_datapath #(
    .WIDTH    (WIDTH),
    .LOWPOWER (LOWPOWER),
    .ADD_CONST(ADD_CONST),
    .XOR_MASK (XOR_MASK),
    .SHIFT_AMT(SHIFT_AMT)
  ) uDp (
    .strobes  (strobes),
    .dataIn   (dataIn),
    .heldOps  (heldOps),
    .branchRes(branchRes),
    .chainOut (result)
  );

  assign heldOperands = heldOps;

  // Output must come from the branch named by the first set condition.
  always_comb begin
    int pick;
    pick = DEFAULT_IX;
    for (int k = NUM_COND - 1; k >= 0; k--) begin
      if (condVec[k]) pick = k;
    end
    if (!$isunknown({condVec, dataIn})) begin
      a_r2_first_cond_wins: assert (result == branchRes[pick])
        else $error("R2: output not taken from branch %0d", pick);
      a_r4_single_open: assert ($onehot(strobes.latchOpen) && strobes.latchOpen[pick])
        else $error("R4: isolation enables disagree with priority");
      if (condVec[0]) begin
        a_r1_top_cond_adds: assert (result == WIDTH'(dataIn + ADD_CONST))
          else $error("R1: highest-priority branch value wrong");
      end
    end
  end

endmodule

// File: tb/prio_branch_sel_test.sv
`timescale 1ns/1ps
module prio_branch_sel_test;

  localparam int               W    = 16;
  localparam int               NB   = 5;
  localparam logic [W-1:0]     ADDC = 16'h0035;
  localparam logic [W-1:0]     XM   = 16'hA5C3;
  localparam int               SH   = 3;

  logic           clk = 1'b0;
  logic           rstN;
  logic [3:0]     condVec;
  logic [W-1:0]   dataIn;
  logic [W-1:0]   resLp, resWire;
  logic [NB*W-1:0] heldLp, heldWire;

  int totalCnt = 0;
  int badCnt   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  prio_branch_sel #(.WIDTH(W), .LOWPOWER(1'b1), .ADD_CONST(ADDC), .XOR_MASK(XM), .SHIFT_AMT(SH)) uut (
    .condVec(condVec), .dataIn(dataIn), .result(resLp), .heldOperands(heldLp));

  prio_branch_sel #(.WIDTH(W), .LOWPOWER(1'b0), .ADD_CONST(ADDC), .XOR_MASK(XM), .SHIFT_AMT(SH)) uutWire (
    .condVec(condVec), .dataIn(dataIn), .result(resWire), .heldOperands(heldWire));

  function automatic logic [W-1:0] refModel(input logic [3:0] c, input logic [W-1:0] x);
    if (c[0])      return x + ADDC;
    else if (c[1]) return x ^ XM;
    else if (c[2]) return x << SH;
    else if (c[3]) return ~x;
    else           return x;
  endfunction

  function automatic int firstIdx(input logic [3:0] c);
    for (int k = 0; k < 4; k++) if (c[k]) return k;
    return 4;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    totalCnt++;
    if (act !== exp) begin
      badCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [W-1:0] x);
    @(posedge clk);
    #0.5;
    condVec = c;
    dataIn  = x;
    @(negedge clk);
  endtask

  // R3: idle pattern straight after reset.
  task automatic tIdle();
    apply(4'b0000, 16'h0000);
    check("R3 reset idle", resLp, 16'h0000);
    apply(4'b0000, 16'h1234);
    check("R3 default pass", resLp, 16'h1234);
  endtask

  // R1 R2 R3 R5 R7 R8 R9: every condition pattern with several data words.
  task automatic tPriority();
    logic [W-1:0] words [4] = '{16'h0000, 16'h1234, 16'hFFFF, 16'h8001};
    for (int w = 0; w < 4; w++) begin
      for (int c = 0; c < 16; c++) begin
        int fi;
        apply(c[3:0], words[w]);
        fi = firstIdx(c[3:0]);
        if (c[0]) check("R1 top condition", resLp, refModel(c[3:0], words[w]));
        else if (c == 0) check("R3 no condition", resLp, words[w]);
        else check("R2 first set condition", resLp, refModel(c[3:0], words[w]));
        check("R8 modes agree", resWire, resLp);
        check("R5 R9 chosen operand", heldLp[fi*W +: W], words[w]);
        for (int b = 0; b < NB; b++) check("R7 R9 wired operand", heldWire[b*W +: W], words[w]);
      end
    end
  endtask

  // R1: wrap-around of the adder branch.
  task automatic tWrap();
    apply(4'b1111, 16'hFFFF);
    check("R1 add wraps", resLp, 16'h0034);
    apply(4'b0001, 16'hFFD0);
    check("R1 add wraps low", resLp, 16'h0005);
  endtask

  // R4: lower-priority bits are ignored.
  task automatic tLowerIgnored();
    for (int hi = 0; hi < 4; hi++) begin
      apply({hi[1:0], 2'b10}, 16'h0F0F);
      check("R4 lower bits ignored", resLp, 16'h0F0F ^ XM);
    end
    apply(4'b1100, 16'h4001);
    check("R4 stage2 over stage3", resLp, 16'h0008);
  endtask

  // R6: closed stages hold their last operand while data moves.
  task automatic tFreeze();
    apply(4'b0010, 16'hAAAA);   // branch 1 takes 0xAAAA
    apply(4'b0100, 16'hAAAA);   // branch 1 closes; branch 2 takes 0xAAAA
    apply(4'b0100, 16'h5555);   // branch 2 follows
    apply(4'b0000, 16'h5555);   // branch 2 closes holding 0x5555
    apply(4'b0000, 16'h7777);
    check("R6 branch1 frozen", heldLp[1*W +: W], 16'hAAAA);
    check("R6 branch2 frozen", heldLp[2*W +: W], 16'h5555);
    check("R5 default follows", heldLp[4*W +: W], 16'h7777);
    apply(4'b0000, 16'h1111);
    check("R6 branch1 still frozen", heldLp[1*W +: W], 16'hAAAA);
    check("R6 branch2 still frozen", heldLp[2*W +: W], 16'h5555);
    check("R8 freeze result", resLp, resWire);
  endtask

  initial begin
    rstN    = 1'b0;
    condVec = 4'b0000;
    dataIn  = '0;
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    tIdle();
    tPriority();
    tWrap();
    tLowerIgnored();
    tFreeze();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      badCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", totalCnt, badCnt);
      $finish;
    end
  end

endmodule